// File: doc/BRIEF.md
# Debug Hart Handshake Window

This block is the bus-facing status window of an execution-based debug module. It decodes a 512-byte address window at the top of the address space into four 128-byte regions: code ROM, program buffer, data buffer and status. It implements the status region itself. The storage behind the other three regions lives elsewhere. The block raises one select line per region so that the neighbouring storage can respond.

A halted hart spins in a park loop and polls the status region. Each hart owns one byte lane of the status word, and two request bits in that lane tell the hart whether to resume or to run the program buffer. The hart reports progress with word writes into the status region. The word offset of the write selects the kind of acknowledge, and the write data carries the hart number.

On the debugger side there is a single command port. It posts halt, resume and execute requests, and it clears the sticky error flag. For each hart the block reports whether it is halted, running or busy in the buffer, whether an exception has been seen, and whether a halt request is pending.

Top module: `dbg_hart_window`

## Requirements
- R1: `region_sel` is a pure function of `bus_addr`. Bit 0 marks code ROM (base 0xFFFFFE00), bit 1 the program buffer (0xFFFFFE80), bit 2 the data buffer (0xFFFFFF00) and bit 3 the status region (0xFFFFFF80). An address outside the 512-byte window gives all zeros.
- R2: A read (`bus_re`) returns `bus_rdata` on the clock edge that follows it. For a status-region read, byte lane N belongs to hart N, with bit 0 the resume request and bit 1 the execute request. Lanes whose `bus_be` bit is low, lanes of absent harts, and reads outside the status region return zero. With no read, `bus_rdata` is zero.
- R3: A word-aligned write to status offset 0x0 whose data equals a present hart number is a halt acknowledge for that hart. It sets the hart's halted flag (running goes low) and clears its busy flag and its pending halt request. A hart number at or above the hart count is ignored.
- R4: A write to status offset 0x4 carrying a hart number clears that hart's halted flag and its resume request.
- R5: A write to status offset 0x8 carrying a hart number clears that hart's execute request and sets its busy flag.
- R6: A write to status offset 0xC, whatever its data, sets the error flag of every hart that is busy. A hart that is not busy is unaffected. The error flag stays set until a clear-error command (op 3) is given for that hart.
- R7: Resume (op 1) and execute (op 2) commands take effect only while the addressed hart is halted and not busy. Otherwise they are ignored. Both requests may be pending at once.
- R8: A halt command (op 0) raises the hart's halt request only while the hart is running. When the hart is halted, the command is ignored.
- R9: Writes outside the status region, writes at status offsets of 0x10 or above, and writes that are not word-aligned change no flag.
- R10: After reset no hart is halted, busy or in error, no request of any kind is pending, and every hart reports running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | CPU bus byte address |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for reads |
| bus_wdata | input | 32 | Write data (hart number for acknowledges) |
| bus_rdata | output | 32 | Registered read data |
| region_sel | output | 4 | One-hot region select (ROM, buffer, data, status) |
| dbg_valid | input | 1 | Debugger command strobe |
| dbg_op | input | 2 | 0 halt, 1 resume, 2 execute, 3 clear error |
| dbg_hart | input | 2 | Target hart of the command |
| hart_halted | output | NUM_HARTS | Hart is parked in debug mode |
| hart_running | output | NUM_HARTS | Hart is not halted |
| hart_busy | output | NUM_HARTS | Hart is executing the program buffer |
| hart_error | output | NUM_HARTS | Sticky exception flag |
| hart_halt_req | output | NUM_HARTS | Pending halt request toward the hart |

## Verification
The bench builds the block with NUM_HARTS set to 3, so the hart count is one short of the full status word. With this value the fourth byte lane must read as zero, and an acknowledge that carries hart number 3 tests the rejection of an absent hart. The address window stays at its default base, so all four region bases and an address outside the window are exercised against the fixed map.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;
   typedef enum logic [1:0] {
      OP_HALT   = 2'd0,
      OP_RESUME = 2'd1,
      OP_EXEC   = 2'd2,
      OP_CLRERR = 2'd3
   } dbg_op_e;

   // acknowledge kind is the word index inside the status region
   localparam logic [1:0] ACK_HALT   = 2'd0;
   localparam logic [1:0] ACK_RESUME = 2'd1;
   localparam logic [1:0] ACK_EXEC   = 2'd2;
   localparam logic [1:0] ACK_EXCEPT = 2'd3;

   localparam int WIN_BYTES    = 512;
   localparam int REGION_COUNT = 4;
   localparam int REGION_BYTES = WIN_BYTES / REGION_COUNT;
   localparam int STAT_REGION  = 3;
endpackage

// File: rtl/dbgwin_decode.sv
module dbgwin_decode
   import dbgwin_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_FE00
) (
   input  logic [ADDR_W-1:0]       addr,
   output logic [REGION_COUNT-1:0] region_sel,
   output logic                    ack_ok,
   output logic [1:0]              ack_kind
);
   localparam int WIN_LSB = $clog2(WIN_BYTES);
   localparam int REG_LSB = $clog2(REGION_BYTES);
   localparam int ACK_TOP = 4;

   initial begin
      if (WIN_BASE[WIN_LSB-1:0] != '0) $fatal(1, "window base not aligned");
      if (ADDR_W <= WIN_LSB)           $fatal(1, "address too narrow");
   end

   logic                         in_win;
   logic [$clog2(REGION_COUNT)-1:0] reg_idx;

   always_comb begin
      in_win     = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
      reg_idx    = addr[WIN_LSB-1:REG_LSB];
      region_sel = in_win ? (REGION_COUNT'(1) << reg_idx) : '0;
      ack_kind   = addr[ACK_TOP-1:2];
      ack_ok     = region_sel[STAT_REGION]
                   && (addr[REG_LSB-1:ACK_TOP] == '0)
                   && (addr[1:0] == 2'b00);
   end
endmodule

// File: rtl/dbgwin_hart_slot.sv
module dbgwin_hart_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_halt,
   input  logic ack_resume,
   input  logic ack_exec,
   input  logic ack_exc,
   input  logic cmd_halt,
   input  logic cmd_resume,
   input  logic cmd_exec,
   input  logic cmd_clr,
   output logic halted_o,
   output logic busy_o,
   output logic err_o,
   output logic resume_req_o,
   output logic exec_req_o,
   output logic halt_req_o
);
   logic halted_q, busy_q, err_q, rreq_q, xreq_q, hreq_q;
   logic accept;

   assign accept = halted_q && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         busy_q   <= 1'b0;
         err_q    <= 1'b0;
         rreq_q   <= 1'b0;
         xreq_q   <= 1'b0;
         hreq_q   <= 1'b0;
      end else begin
         if (ack_halt)             halted_q <= 1'b1;
         else if (ack_resume)      halted_q <= 1'b0;

         if (ack_halt)             busy_q <= 1'b0;
         else if (ack_exec)        busy_q <= 1'b1;

         if (ack_exc)              err_q <= 1'b1;
         else if (cmd_clr)         err_q <= 1'b0;

         if (ack_halt)             hreq_q <= 1'b0;
         else if (cmd_halt && !halted_q) hreq_q <= 1'b1;

         if (cmd_resume && accept) rreq_q <= 1'b1;
         else if (ack_resume)      rreq_q <= 1'b0;

         if (cmd_exec && accept)   xreq_q <= 1'b1;
         else if (ack_exec)        xreq_q <= 1'b0;
      end
   end

   assign halted_o     = halted_q;
   assign busy_o       = busy_q;
   assign err_o        = err_q;
   assign resume_req_o = rreq_q;
   assign exec_req_o   = xreq_q;
   assign halt_req_o   = hreq_q;
endmodule

// File: rtl/dbgwin_rdport.sv
module dbgwin_rdport #(
   parameter int NUM_HARTS = 4,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_stat,
   input  logic [DATA_W/8-1:0]  be,
   input  logic [NUM_HARTS-1:0] resume_req,
   input  logic [NUM_HARTS-1:0] exec_req,
   output logic [DATA_W-1:0]    rdata
);
   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] word;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      if (b < NUM_HARTS) begin : g_live
         assign word[8*b +: 8] = be[b] ? {6'b0, exec_req[b], resume_req[b]} : 8'h00;
      end else begin : g_absent
         assign word[8*b +: 8] = 8'h00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (rd_stat) rdata <= word;
      else              rdata <= '0;
   end
endmodule

// File: rtl/dbg_hart_window.sv
module dbg_hart_window
   import dbgwin_pkg::*;
#(
   parameter int                NUM_HARTS = 4,
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'hFFFF_FE00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_re,
   input  logic                 bus_we,
   input  logic [3:0]           bus_be,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [3:0]           region_sel,
   input  logic                 dbg_valid,
   input  logic [1:0]           dbg_op,
   input  logic [1:0]           dbg_hart,
   output logic [NUM_HARTS-1:0] hart_halted,
   output logic [NUM_HARTS-1:0] hart_running,
   output logic [NUM_HARTS-1:0] hart_busy,
   output logic [NUM_HARTS-1:0] hart_error,
   output logic [NUM_HARTS-1:0] hart_halt_req
);
   initial begin
      if (NUM_HARTS < 1 || NUM_HARTS > 4) $fatal(1, "hart count must be 1..4");
   end

   logic       ack_ok;
   logic [1:0] ack_kind;
   logic       wr_ack;
   dbg_op_e    op;

   logic [NUM_HARTS-1:0] halted_w, busy_w, err_w, resume_req_w, exec_req_w, halt_req_w;

   dbgwin_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
      .addr       (bus_addr),
      .region_sel (region_sel),
      .ack_ok     (ack_ok),
      .ack_kind   (ack_kind)
   );

   assign wr_ack = bus_we && ack_ok;
   assign op     = dbg_op_e'(dbg_op);

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic id_hit, cmd_hit;
      assign id_hit  = (bus_wdata == 32'(h));
      assign cmd_hit = dbg_valid && (dbg_hart == 2'(h));

      dbgwin_hart_slot u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .ack_halt     (wr_ack && ack_kind == ACK_HALT   && id_hit),
         .ack_resume   (wr_ack && ack_kind == ACK_RESUME && id_hit),
         .ack_exec     (wr_ack && ack_kind == ACK_EXEC   && id_hit),
         .ack_exc      (wr_ack && ack_kind == ACK_EXCEPT && busy_w[h]),
         .cmd_halt     (cmd_hit && op == OP_HALT),
         .cmd_resume   (cmd_hit && op == OP_RESUME),
         .cmd_exec     (cmd_hit && op == OP_EXEC),
         .cmd_clr      (cmd_hit && op == OP_CLRERR),
         .halted_o     (halted_w[h]),
         .busy_o       (busy_w[h]),
         .err_o        (err_w[h]),
         .resume_req_o (resume_req_w[h]),
         .exec_req_o   (exec_req_w[h]),
         .halt_req_o   (halt_req_w[h])
      );
   end

   dbgwin_rdport #(.NUM_HARTS(NUM_HARTS), .DATA_W(32)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_stat    (bus_re && region_sel[STAT_REGION]),
      .be         (bus_be),
      .resume_req (resume_req_w),
      .exec_req   (exec_req_w),
      .rdata      (bus_rdata)
   );

   assign hart_halted   = halted_w;
   assign hart_running  = ~halted_w;
   assign hart_busy     = busy_w;
   assign hart_error    = err_w;
   assign hart_halt_req = halt_req_w;
endmodule

// File: rtl/dbgwin_checker.sv
module dbgwin_checker #(
   parameter int NUM_HARTS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_re,
   input logic [31:0]          bus_rdata,
   input logic                 dbg_valid,
   input logic [1:0]           dbg_op,
   input logic [1:0]           dbg_hart,
   input logic [NUM_HARTS-1:0] halted,
   input logic [NUM_HARTS-1:0] busy,
   input logic [NUM_HARTS-1:0] err,
   input logic [NUM_HARTS-1:0] resume_req,
   input logic [NUM_HARTS-1:0] exec_req,
   input logic [NUM_HARTS-1:0] halt_req
);
   // R2: read data is zero in the cycle after an idle read strobe
   p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> (bus_rdata == 32'h0));

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
      // R7: a new resume request only while parked and idle
      p_resume_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(resume_req[h]) |-> $past(halted[h] && !busy[h]));

      // R7: a new execute request only while parked and idle
      p_exec_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(exec_req[h]) |-> $past(halted[h] && !busy[h]));

      // R6: error flag only falls after a clear command for this hart
      p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(err[h]) |-> $past(dbg_valid && dbg_op == 2'd3 && dbg_hart == 2'(h)));

      // R3: entering the halted state leaves no busy flag and no halt request
      p_halt_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(halted[h]) |-> (!busy[h] && !halt_req[h]));
   end
endmodule

bind dbg_hart_window dbgwin_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_re     (bus_re),
   .bus_rdata  (bus_rdata),
   .dbg_valid  (dbg_valid),
   .dbg_op     (dbg_op),
   .dbg_hart   (dbg_hart),
   .halted     (halted_w),
   .busy       (busy_w),
   .err        (err_w),
   .resume_req (resume_req_w),
   .exec_req   (exec_req_w),
   .halt_req   (halt_req_w)
);

// File: tb/sim_dbg_hart_window.sv
module sim_dbg_hart_window;
   localparam int NH = 3;
   localparam logic [31:0] ROM  = 32'hFFFF_FE00;
   localparam logic [31:0] PBUF = 32'hFFFF_FE80;
   localparam logic [31:0] DBUF = 32'hFFFF_FF00;
   localparam logic [31:0] STAT = 32'hFFFF_FF80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   bus_addr = '0;
   logic          bus_re = 1'b0, bus_we = 1'b0;
   logic [3:0]    bus_be = 4'hF;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [3:0]    region_sel;
   logic          dbg_valid = 1'b0;
   logic [1:0]    dbg_op = '0, dbg_hart = '0;
   logic [NH-1:0] halted, running, busy, err, hreq;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        issued;

   always #2 clk = ~clk;

   dbg_hart_window #(.NUM_HARTS(NH)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
      .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .region_sel(region_sel), .dbg_valid(dbg_valid),
      .dbg_op(dbg_op), .dbg_hart(dbg_hart), .hart_halted(halted),
      .hart_running(running), .hart_busy(busy), .hart_error(err),
      .hart_halt_req(hreq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard for every read issued on the previous edge
   initial forever begin
      @(posedge clk);
      issued = bus_re;
      @(negedge clk);
      if (issued) begin
         if (exp_q.size() == 0) chk("R2 unexpected read", bus_rdata, 32'hx);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   task automatic bwr(input logic [31:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0; bus_addr = '0;
   endtask

   task automatic brd(input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      bus_addr = a; bus_be = be; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0; bus_addr = '0; bus_be = 4'hF;
   endtask

   task automatic dcmd(input logic [1:0] op, input logic [1:0] h);
      dbg_valid = 1'b1; dbg_op = op; dbg_hart = h;
      @(negedge clk);
      dbg_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 halted",  32'(halted),  0);
      chk("R10 running", 32'(running), 32'h7);
      chk("R10 busy",    32'(busy),    0);
      chk("R10 error",   32'(err),     0);
      chk("R10 haltreq", 32'(hreq),    0);
      brd(STAT, 4'hF, 32'h0, "R10 request word");

      // R1 region decode
      bus_addr = ROM + 32'h10; #1 chk("R1 rom",  32'(region_sel), 32'h1);
      bus_addr = PBUF;         #1 chk("R1 pbuf", 32'(region_sel), 32'h2);
      bus_addr = DBUF + 4;     #1 chk("R1 data", 32'(region_sel), 32'h4);
      bus_addr = STAT + 32'h70;#1 chk("R1 stat", 32'(region_sel), 32'h8);
      bus_addr = 32'h0000_1000;#1 chk("R1 outside", 32'(region_sel), 32'h0);
      bus_addr = 32'hFFFF_FC00;#1 chk("R1 below", 32'(region_sel), 32'h0);
      bus_addr = '0;
      @(negedge clk);

      // R7 resume while running ignored
      dcmd(2'd1, 2'd1);
      brd(STAT, 4'hF, 32'h0, "R7 resume while running");

      // R8 halt request, R3 halt ack
      dcmd(2'd0, 2'd1);
      chk("R8 halt request raised", 32'(hreq), 32'h2);
      bwr(STAT + 0, 32'd1);
      chk("R3 halted", 32'(halted), 32'h2);
      chk("R3 running", 32'(running), 32'h5);
      chk("R3 halt request cleared", 32'(hreq), 32'h0);
      dcmd(2'd0, 2'd1);
      chk("R8 halt ignored while halted", 32'(hreq), 32'h0);

      // R7, R2 both requests pending, byte lanes
      dcmd(2'd2, 2'd1);
      dcmd(2'd1, 2'd1);
      brd(STAT, 4'hF, 32'h0000_0300, "R2 both bits hart1");
      brd(STAT + 1, 4'b0010, 32'h0000_0300, "R2 byte lane hart1");
      brd(STAT, 4'b0001, 32'h0, "R2 disabled lane");

      // R5 execute ack
      bwr(STAT + 32'h8, 32'd1);
      chk("R5 busy", 32'(busy), 32'h2);
      brd(STAT, 4'hF, 32'h0000_0100, "R5 exec request cleared");

      // R7 execute while busy ignored
      dcmd(2'd2, 2'd1);
      brd(STAT, 4'hF, 32'h0000_0100, "R7 exec while busy");

      // R6 exception ack, sticky
      bwr(STAT + 32'hC, 32'd0);
      chk("R6 error on busy hart", 32'(err), 32'h2);
      bwr(STAT + 0, 32'd1);
      chk("R3 busy cleared by halt ack", 32'(busy), 32'h0);
      chk("R6 error sticky", 32'(err), 32'h2);

      // R4 resume ack
      bwr(STAT + 32'h4, 32'd1);
      chk("R4 halted cleared", 32'(halted), 32'h0);
      brd(STAT, 4'hF, 32'h0, "R4 resume request cleared");
      chk("R6 error still set", 32'(err), 32'h2);
      dcmd(2'd3, 2'd1);
      chk("R6 error cleared", 32'(err), 32'h0);

      // R3, R9 ignored writes
      bwr(STAT + 0, 32'd3);
      chk("R3 absent hart id", 32'(halted), 32'h0);
      bwr(STAT + 32'h10, 32'd0);
      chk("R9 high offset", 32'(halted), 32'h0);
      bwr(DBUF, 32'd0);
      chk("R9 data region", 32'(halted), 32'h0);
      bwr(STAT + 2, 32'd0);
      chk("R9 unaligned", 32'(halted), 32'h0);

      // hart 2 path
      bwr(STAT + 0, 32'd2);
      chk("R3 hart2 halted", 32'(halted), 32'h4);
      dcmd(2'd2, 2'd2);
      brd(STAT, 4'hF, 32'h0002_0000, "R2 hart2 exec bit");
      brd(DBUF, 4'hF, 32'h0, "R2 non-status region");
      brd(STAT, 4'b1000, 32'h0, "R2 absent hart lane");

      // R6 exception with no busy hart
      bwr(STAT + 32'hC, 32'd0);
      chk("R6 no busy hart", 32'(err), 32'h0);

      @(negedge clk);
      finish_run();
   end
endmodule